// File: doc/BRIEF.md
# Quad-Data-Rate Four-Word Burst SRAM

This block is a synthesizable, reduced-depth model of a burst static memory. It has a write data port and a read data port that are independent of each other, and one address bus that the two kinds of command share. Every command moves four consecutive 36-bit words. The words travel at two per clock cycle, one on each half of the cycle. Double-data-rate timing is modelled with an internal clock `clk2x` that runs at twice the command rate. A phase register inside the block splits each pair of `clk2x` edges into a true-clock half (phase 0) and a complementary half (phase 1). A cycle-parity register splits the command cycles into even and odd cycles.

The shared address bus alternates between the two command types. A read is accepted only on the phase-0 edge of an even cycle, and a write only on the phase-0 edge of an odd cycle. Counted from the first `clk2x` edge after reset is released, read slots are edges 0, 4, 8, … and write slots are edges 2, 6, 10, …. A write burst takes its data and its lane masks on the command edge and on the three edges that follow. A read burst drives its words after a latency that `lat_hi` selects: 2.5 cycles or 1 cycle. `dout_vld` frames exactly the half-cycles that carry read words.

The storage is split into four equal banks, and the top two bits of the burst address select the bank. The read side is a controller with states RD_IDLE and RD_BURST. The transition RD_IDLE→RD_BURST happens when a delayed read request reaches the selected latency tap. RD_BURST stays in RD_BURST while the beat count is below 3, and takes RD_BURST→RD_IDLE after beat 3. The write side is a controller with states WR_IDLE and WR_BURST. It takes WR_IDLE→WR_BURST on an accepted write command and WR_BURST→WR_IDLE after beat 3. When a word is read on the same half-cycle in which it is written, the written lanes are forwarded to the read port.

Top module: `qdr_burst_sram`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, `dout_vld` is 0 and `dout` is 0.
- R2: A read command is accepted only when `rd_sel_n` is 0 on a read slot (edge index ≡ 0 mod 4 after reset release). A write command is accepted only when `wr_sel_n` is 0 on a write slot (edge index ≡ 2 mod 4). A select that is low on any other edge starts no burst and changes no stored word.
- R3: A write burst at burst address A stores `din` at word address {A,b} for beat b = 0..3. Beat b is sampled on the command edge plus b `clk2x` edges.
- R4: `lane_en_n[i]` = 0 writes bits [9i+8:9i] of the current beat. `lane_en_n[i]` = 1 leaves those 9 stored bits unchanged. Each beat has its own mask.
- R5: With `lat_hi` = 1, read beat b of a command accepted on edge E is driven on edge E+5+b, which is 2.5 cycles after the command.
- R6: With `lat_hi` = 0, read beat b of a command accepted on edge E is driven on edge E+2+b, which is 1 cycle after the command.
- R7: `dout_vld` is 1 for exactly the four half-cycles of each read burst. Outside those half-cycles, `dout` is 0.
- R8: A word that is read on the same edge on which a write beat stores it returns the new value in the enabled lanes and the old value in the masked lanes.
- R9: Burst address bits [5:4] select one of four banks. Bursts written to different banks are all held independently.
- R10: Reads accepted on two consecutive read slots with `lat_hi` = 1 produce eight back-to-back valid words with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Double-rate clock; each edge is one data half-cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_hi | input | 1 | Read latency select: 1 = 2.5 cycles, 0 = 1 cycle |
| addr | input | 6 | Shared burst address (four-word aligned) |
| rd_sel_n | input | 1 | Active-low read command select |
| wr_sel_n | input | 1 | Active-low write command select |
| lane_en_n | input | 4 | Active-low per-lane write enables for the current beat |
| din | input | 36 | Write data for the current beat |
| dout | output | 36 | Read data, zero when not valid |
| dout_vld | output | 1 | High while `dout` carries a read word |

## Verification
On every cycle the assertions check the following. The first valid read word appears exactly 3 or 6 edges after an accepted read, matching `lat_hi`. It rises only at the edge offset that a read slot permits. Valid windows and array-write activity both come in whole multiples of four half-cycles. Only the bench's scenarios can show the rest: that each stored word and each masked lane holds the right value, that forwarding works when a read and a write meet on the same half-cycle, that the four banks keep separate contents, and that selects on the wrong slot leave the memory untouched.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = 2;
    // read latency in half-cycles for each mode
    localparam int LAT_HI_HC = 5;
    localparam int LAT_LO_HC = 2;

    typedef enum logic {RD_IDLE, RD_BURST} rd_state_t;
    typedef enum logic {WR_IDLE, WR_BURST} wr_state_t;
endpackage

// File: rtl/qdr_bank.sv
module qdr_bank #(
    parameter int DEPTH_W = 6,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9
) (
    input  logic                      clk2x,
    input  logic                      we,
    input  logic [DEPTH_W-1:0]        waddr,
    input  logic [LANES-1:0]          lane_we,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [DEPTH_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DW    = LANES * LANE_W;
    localparam int WORDS = 2 ** DEPTH_W;

    logic [DW-1:0] store [WORDS];

    always_ff @(posedge clk2x) begin
        for (int i = 0; i < LANES; i++) begin
            if (we && lane_we[i]) begin
                store[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/qdr_wr_ctrl.sv
module qdr_wr_ctrl import qdr_pkg::*; #(
    parameter int AW = 6
) (
    input  logic                 clk2x,
    input  logic                 rst_n,
    input  logic                 wr_acc,
    input  logic [AW-1:0]        cmd_addr,
    output logic                 wr_fire,
    output logic [AW+BEAT_W-1:0] wr_word
);
    wr_state_t       state, state_n;
    logic [BEAT_W-1:0] beat, beat_n;
    logic [AW-1:0]   base, base_n;

    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            state <= WR_IDLE;
            beat  <= '0;
            base  <= '0;
        end else begin
            state <= state_n;
            beat  <= beat_n;
            base  <= base_n;
        end
    end

    always_comb begin
        state_n = state;
        beat_n  = beat;
        base_n  = base;
        unique case (state)
            WR_IDLE: begin
                if (wr_acc) begin
                    state_n = WR_BURST;
                    beat_n  = BEAT_W'(1);
                    base_n  = cmd_addr;
                end
            end
            WR_BURST: begin
                beat_n = beat + 1'b1;
                if (beat == BEAT_W'(BURST_LEN - 1)) state_n = WR_IDLE;
            end
            default: state_n = WR_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            WR_IDLE: begin
                wr_fire = wr_acc;
                wr_word = {cmd_addr, {BEAT_W{1'b0}}};
            end
            WR_BURST: begin
                wr_fire = 1'b1;
                wr_word = {base, beat};
            end
            default: begin
                wr_fire = 1'b0;
                wr_word = '0;
            end
        endcase
    end
endmodule

// File: rtl/qdr_rd_ctrl.sv
module qdr_rd_ctrl import qdr_pkg::*; #(
    parameter int AW = 6
) (
    input  logic                 clk2x,
    input  logic                 rst_n,
    input  logic                 rd_acc,
    input  logic                 lat_hi,
    input  logic [AW-1:0]        cmd_addr,
    output logic                 rd_fire,
    output logic [AW+BEAT_W-1:0] rd_word
);
    localparam int DLY = LAT_HI_HC;

    logic [DLY-1:0] pend_v;
    logic [AW-1:0]  pend_a [DLY];
    logic           start;
    logic [AW-1:0]  start_a;

    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            pend_v <= '0;
            for (int k = 0; k < DLY; k++) pend_a[k] <= '0;
        end else begin
            pend_v    <= {pend_v[DLY-2:0], rd_acc};
            pend_a[0] <= cmd_addr;
            for (int k = 1; k < DLY; k++) pend_a[k] <= pend_a[k-1];
        end
    end

    assign start   = lat_hi ? pend_v[LAT_HI_HC-1] : pend_v[LAT_LO_HC-1];
    assign start_a = lat_hi ? pend_a[LAT_HI_HC-1] : pend_a[LAT_LO_HC-1];

    rd_state_t         state, state_n;
    logic [BEAT_W-1:0] beat, beat_n;
    logic [AW-1:0]     base, base_n;

    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            state <= RD_IDLE;
            beat  <= '0;
            base  <= '0;
        end else begin
            state <= state_n;
            beat  <= beat_n;
            base  <= base_n;
        end
    end

    always_comb begin
        state_n = state;
        beat_n  = beat;
        base_n  = base;
        unique case (state)
            RD_IDLE: begin
                if (start) begin
                    state_n = RD_BURST;
                    beat_n  = BEAT_W'(1);
                    base_n  = start_a;
                end
            end
            RD_BURST: begin
                beat_n = beat + 1'b1;
                if (beat == BEAT_W'(BURST_LEN - 1)) state_n = RD_IDLE;
            end
            default: state_n = RD_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            RD_IDLE: begin
                rd_fire = start;
                rd_word = {start_a, {BEAT_W{1'b0}}};
            end
            RD_BURST: begin
                rd_fire = 1'b1;
                rd_word = {base, beat};
            end
            default: begin
                rd_fire = 1'b0;
                rd_word = '0;
            end
        endcase
    end
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram import qdr_pkg::*; #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int BANKS  = 4
) (
    input  logic                    clk2x,
    input  logic                    rst_n,
    input  logic                    lat_hi,
    input  logic [AW-1:0]           addr,
    input  logic                    rd_sel_n,
    input  logic                    wr_sel_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_vld
);
    localparam int DW        = LANES * LANE_W;
    localparam int WAW       = AW + BEAT_W;
    localparam int BANK_BITS = $clog2(BANKS);
    localparam int BANK_AW   = WAW - BANK_BITS;

    // half-cycle phase and command-cycle parity
    logic ph, odd_cyc;
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            ph      <= 1'b0;
            odd_cyc <= 1'b0;
        end else begin
            ph <= ~ph;
            if (ph) odd_cyc <= ~odd_cyc;
        end
    end

    logic rd_acc, wr_acc;
    assign rd_acc = !rd_sel_n && !ph && !odd_cyc;
    assign wr_acc = !wr_sel_n && !ph && odd_cyc;

    logic           wr_fire, rd_fire;
    logic [WAW-1:0] wr_word, rd_word;

    qdr_wr_ctrl #(.AW(AW)) i_wr (
        .clk2x   (clk2x),
        .rst_n   (rst_n),
        .wr_acc  (wr_acc),
        .cmd_addr(addr),
        .wr_fire (wr_fire),
        .wr_word (wr_word)
    );

    qdr_rd_ctrl #(.AW(AW)) i_rd (
        .clk2x   (clk2x),
        .rst_n   (rst_n),
        .rd_acc  (rd_acc),
        .lat_hi  (lat_hi),
        .cmd_addr(addr),
        .rd_fire (rd_fire),
        .rd_word (rd_word)
    );

    logic [DW-1:0] bank_q [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_fire && (wr_word[WAW-1 -: BANK_BITS] == BANK_BITS'(b));
        qdr_bank #(.DEPTH_W(BANK_AW), .LANES(LANES), .LANE_W(LANE_W)) i_bank (
            .clk2x  (clk2x),
            .we     (bank_we),
            .waddr  (wr_word[BANK_AW-1:0]),
            .lane_we(~lane_en_n),
            .wdata  (din),
            .raddr  (rd_word[BANK_AW-1:0]),
            .rdata  (bank_q[b])
        );
    end

    logic [DW-1:0] rd_raw, rd_merged;
    logic          fwd;
    assign rd_raw = bank_q[rd_word[WAW-1 -: BANK_BITS]];
    assign fwd    = wr_fire && (wr_word == rd_word);

    for (genvar i = 0; i < LANES; i++) begin : g_fwd
        assign rd_merged[i*LANE_W +: LANE_W] = (fwd && !lane_en_n[i]) ?
            din[i*LANE_W +: LANE_W] : rd_raw[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout     <= rd_fire ? rd_merged : '0;
            dout_vld <= rd_fire;
        end
    end
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk import qdr_pkg::*; (
    input logic clk2x,
    input logic rst_n,
    input logic lat_hi,
    input logic dout_vld,
    input logic rd_acc,
    input logic wr_fire
);
    logic [1:0] slot;
    logic [7:0] vld_run, wr_run;

    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            slot    <= '0;
            vld_run <= '0;
            wr_run  <= '0;
        end else begin
            slot    <= slot + 1'b1;
            vld_run <= dout_vld ? vld_run + 1'b1 : '0;
            wr_run  <= wr_fire  ? wr_run + 1'b1  : '0;
        end
    end

    // R5 R6
    rd_latency_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(dout_vld) |-> (lat_hi ? $past(rd_acc, LAT_HI_HC + 1) : $past(rd_acc, LAT_LO_HC + 1)));

    // R2
    rd_slot_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(dout_vld) |-> (slot == (lat_hi ? 2'd2 : 2'd3)));

    // R2
    wr_slot_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(wr_fire) |-> (slot == 2'd2));

    // R7
    vld_len_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!dout_vld && vld_run != 8'd0) |-> (vld_run[1:0] == 2'd0));

    // R3
    wr_len_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!wr_fire && wr_run != 8'd0) |-> (wr_run[1:0] == 2'd0));
endmodule

bind qdr_burst_sram qdr_burst_sram_chk i_chk (
    .clk2x   (clk2x),
    .rst_n   (rst_n),
    .lat_hi  (lat_hi),
    .dout_vld(dout_vld),
    .rd_acc  (rd_acc),
    .wr_fire (wr_fire)
);

// File: tb/test_qdr_burst_sram.sv
`timescale 1ns/1ps
module test_qdr_burst_sram;
    logic        clk2x = 1'b0;
    logic        rst_n = 1'b0;
    logic        lat_hi = 1'b1;
    logic [5:0]  addr = '0;
    logic        rd_sel_n = 1'b1;
    logic        wr_sel_n = 1'b1;
    logic [3:0]  lane_en_n = 4'hF;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_vld;

    int tests = 0;
    int fails = 0;
    int ecnt  = 0;
    logic [35:0] mdl [256];

    always #2.5 clk2x = ~clk2x;

    always @(posedge clk2x) begin
        if (rst_n) ecnt <= ecnt + 1;
        else       ecnt <= 0;
    end

    qdr_burst_sram i_qdr_burst_sram (
        .clk2x(clk2x), .rst_n(rst_n), .lat_hi(lat_hi), .addr(addr),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .lane_en_n(lane_en_n),
        .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half();
        @(negedge clk2x);
    endtask

    task automatic align(input int m);
        while (ecnt % 4 != m) half();
    endtask

    task automatic wait_to(input int n);
        while (ecnt < n) half();
    endtask

    function automatic logic [35:0] pat(input int s);
        logic [31:0] h;
        h = 32'(s) * 32'h9E37_79B9 + 32'h1234_5677;
        return {h[7:4] ^ 4'(s), h};
    endfunction

    function automatic logic [143:0] burst(input int s);
        logic [143:0] r;
        for (int b = 0; b < 4; b++) r[b*36 +: 36] = pat(s * 4 + b);
        return r;
    endfunction

    function automatic void apply(input logic [7:0] w, input logic [35:0] d, input logic [3:0] m);
        for (int i = 0; i < 4; i++)
            if (!m[i]) mdl[w][i*9 +: 9] = d[i*9 +: 9];
    endfunction

    task automatic wr_burst(input logic [5:0] a, input logic [143:0] dv, input logic [15:0] mv);
        align(2);
        for (int b = 0; b < 4; b++) begin
            wr_sel_n  = (b == 0) ? 1'b0 : 1'b1;
            addr      = a;
            din       = dv[b*36 +: 36];
            lane_en_n = mv[b*4 +: 4];
            apply({a, 2'(b)}, din, lane_en_n);
            half();
        end
        wr_sel_n = 1'b1; din = '0; lane_en_n = 4'hF;
    endtask

    task automatic rd_check(input logic [5:0] a, input string req);
        int e, l;
        logic [35:0] exp [4];
        l = lat_hi ? 5 : 2;
        align(0);
        e = ecnt;
        for (int b = 0; b < 4; b++) exp[b] = mdl[{a, 2'(b)}];
        rd_sel_n = 1'b0; addr = a;
        half();
        rd_sel_n = 1'b1;
        wait_to(e + l);
        check({req, " vld before burst"}, 36'(dout_vld), 36'd0);
        for (int b = 0; b < 4; b++) begin
            wait_to(e + l + 1 + b);
            check({req, " vld in burst"}, 36'(dout_vld), 36'd1);
            check({req, " data"}, dout, exp[b]);
        end
        wait_to(e + l + 5);
        check({req, " R7 vld after burst"}, 36'(dout_vld), 36'd0);
        check({req, " R7 dout idle zero"}, dout, 36'd0);
    endtask

    task automatic t_reset();
        repeat (3) half();
        check("R1 vld in reset", 36'(dout_vld), 36'd0);
        check("R1 dout in reset", dout, 36'd0);
        rst_n = 1'b1;
        half();
        check("R1 vld after release", 36'(dout_vld), 36'd0);
        check("R1 dout after release", dout, 36'd0);
    endtask

    task automatic t_long_latency();
        lat_hi = 1'b1;
        wr_burst(6'd5, burst(1), 16'h0000);
        rd_check(6'd5, "R3 R5");
    endtask

    task automatic t_short_latency();
        lat_hi = 1'b0;
        rd_check(6'd5, "R6");
    endtask

    task automatic t_mask();
        lat_hi = 1'b0;
        // beat0 lane0 only, beat1 lanes 1 and 3, beat2 none, beat3 all
        wr_burst(6'd5, burst(2), {4'b0000, 4'b1111, 4'b0101, 4'b1110});
        rd_check(6'd5, "R4");
    endtask

    task automatic t_banks();
        lat_hi = 1'b1;
        for (int k = 0; k < 4; k++) wr_burst({2'(k), 4'h3}, burst(10 + k), 16'h0000);
        for (int k = 0; k < 4; k++) rd_check({2'(k), 4'h3}, "R9");
    endtask

    task automatic t_ignore();
        int e, hits;
        lat_hi = 1'b0;
        wr_burst(6'd9, burst(20), 16'h0000);
        align(0);
        e = ecnt;
        addr = 6'd9; din = pat(999); lane_en_n = 4'h0;
        wr_sel_n = 1'b0; rd_sel_n = 1'b1; half();
        wr_sel_n = 1'b0; rd_sel_n = 1'b0; half();
        wr_sel_n = 1'b1; rd_sel_n = 1'b0; half();
        wr_sel_n = 1'b0; rd_sel_n = 1'b0; half();
        wr_sel_n = 1'b1; rd_sel_n = 1'b1; din = '0; lane_en_n = 4'hF;
        hits = 0;
        while (ecnt < e + 12) begin
            if (dout_vld) hits++;
            half();
        end
        check("R2 stray selects start no read", 36'(hits), 36'd0);
        rd_check(6'd9, "R2 memory untouched");
    endtask

    task automatic t_back_to_back();
        int e;
        logic [35:0] exp [8];
        lat_hi = 1'b1;
        wr_burst(6'd1, burst(30), 16'h0000);
        wr_burst(6'd2, burst(31), 16'h0000);
        for (int b = 0; b < 4; b++) begin
            exp[b]     = mdl[{6'd1, 2'(b)}];
            exp[b + 4] = mdl[{6'd2, 2'(b)}];
        end
        align(0);
        e = ecnt;
        rd_sel_n = 1'b0; addr = 6'd1; half();
        rd_sel_n = 1'b1; half(); half(); half();
        rd_sel_n = 1'b0; addr = 6'd2; half();
        rd_sel_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wait_to(e + 6 + k);
            check("R10 continuous vld", 36'(dout_vld), 36'd1);
            check("R10 data", dout, exp[k]);
        end
        wait_to(e + 14);
        check("R10 vld ends", 36'(dout_vld), 36'd0);
    endtask

    task automatic t_overlap();
        int e;
        logic [143:0] dv;
        logic [15:0]  mv;
        lat_hi = 1'b0;
        wr_burst(6'd7, burst(40), 16'h0000);
        dv = burst(41);
        mv = {4'b0000, 4'b1010, 4'b0110, 4'b0011};
        align(0);
        e = ecnt;
        rd_sel_n = 1'b0; addr = 6'd7; half();
        rd_sel_n = 1'b1; half();
        for (int b = 0; b < 4; b++) begin
            logic [35:0] x;
            wr_sel_n  = (b == 0) ? 1'b0 : 1'b1;
            addr      = 6'd7;
            din       = dv[b*36 +: 36];
            lane_en_n = mv[b*4 +: 4];
            apply({6'd7, 2'(b)}, din, lane_en_n);
            x = mdl[{6'd7, 2'(b)}];
            half();
            check("R8 vld during overlap", 36'(dout_vld), 36'd1);
            check("R8 forwarded data", dout, x);
        end
        wr_sel_n = 1'b1; din = '0; lane_en_n = 4'hF;
        wait_to(e + 7);
        check("R8 vld after overlap", 36'(dout_vld), 36'd0);
        rd_check(6'd7, "R8 stored after overlap");
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_long_latency();
        t_short_latency();
        t_mask();
        t_banks();
        t_ignore();
        t_back_to_back();
        t_overlap();
        repeat (4) half();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule